// File: doc/BRIEF.md
# Region Location Metadata Store

This block is the tag store for a private two-level cache hierarchy whose data arrays carry no address tags of their own. It holds one entry per aligned 4 KB region, and each entry is tagged with the physical page number. The entry records, for each of the region's 64-byte lines, whether the line is resident and where it is: the cache level (L1 or L2) and the way within that level. A line's set index inside a data array is not stored. The data array takes it from the address bits when it accesses the line.

The store is 4-way set associative with 16 sets. It accepts one request per cycle when `ready` is high. There are four request kinds:
- a lookup, which returns the location indicator of one line;
- an allocate, which installs a region;
- a per-line location update;
- a region evict.

Every resident line must have a covering entry. Before an entry is removed, whether by replacement or by an explicit evict, the store walks the entry's resident lines one per cycle. It issues one line-eviction command per line on the way. Each entry also keeps a pointer, with a valid flag, to its copy in a smaller upper-level location cache. Every change the store makes to a line is mirrored to that copy through a dedicated update port.

Top module: `region_loc_store`

## Requirements
- R1: After reset, `ready` is high, `rsp_valid`, `evc_valid` and `upd_valid` are low, and every entry is invalid, so every lookup misses.
- R2: An accepted lookup produces `rsp_valid` for one cycle, on the clock edge after the one that accepted it. The response has the following fields:
  - `rsp_hit` is 1 when a valid entry in set `req_ppn[3:0]` has a tag equal to `req_ppn`.
  - On a hit, `rsp_idx` is set*4+way.
  - On a hit, `rsp_ind` is the indicator of line `req_line`.
- R3: The 6-bit indicator works as follows:
  - Bits [5:3] equal to 3'b001 mean the line is in L1, and 3'b010 mean it is in L2.
  - Bits [2:0] give the way within that level.
  - The value 6'b000000 means the line is not in the private hierarchy.
- R4: An update on a hit behaves as follows:
  - It stores `req_ind` for line `req_line` when the prefix is L1 or L2.
  - With any other prefix it marks the line not resident, and the line then reads 0.
  - A line names at most one level.
  - An update that misses changes no state and answers with `rsp_hit` = 0 and `upd_valid` low.
- R5: An update that hits an entry whose upper pointer is valid pulses `upd_valid` in the same cycle as `rsp_valid`. The pulse carries the entry's pointer, the line number and the line's new indicator. When the pointer is invalid, there is no pulse.
- R6: Allocation works as follows:
  - An allocate for a region that is already present answers `rsp_hit` = 1 with its index and changes nothing.
  - Otherwise it answers `rsp_hit` = 0 and installs the region in the lowest-numbered invalid way of the set.
  - If every way in the set is valid, it installs the region in the way named by the set's rotating pointer. The pointer advances by one on every install into that set.
  - A newly installed entry has every line at 0.
- R7: When the replaced or evicted entry holds resident lines, the walk behaves as follows:
  - `ready` stays low while the store issues one `evc_valid` command per cycle, in ascending line order.
  - Each command carries the region's page, the line number and the line's indicator.
  - If the entry's pointer is valid, an `upd_valid` pulse carrying indicator 0 accompanies each command.
  - The response follows the last command.
- R8: A region evict that hits walks the entry as in R7, then invalidates it and answers `rsp_hit` = 1 with its index. A region evict that misses answers `rsp_hit` = 0 and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 lookup, 1 allocate, 2 update, 3 region evict |
| req_ppn | input | 20 | Physical page number of the region |
| req_line | input | 6 | Line within the region |
| req_ind | input | 6 | New indicator for an update |
| req_uptr | input | 5 | Upper-level entry pointer for an allocate |
| req_uptr_vld | input | 1 | Upper pointer valid for an allocate |
| ready | output | 1 | Store can accept a request |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Region was present |
| rsp_idx | output | 6 | Entry index, set*4+way |
| rsp_ind | output | 6 | Line indicator |
| evc_valid | output | 1 | Line-eviction command |
| evc_ppn | output | 20 | Page of the evicted line |
| evc_line | output | 6 | Line number of the evicted line |
| evc_ind | output | 6 | Location the line leaves |
| upd_valid | output | 1 | Upper-level entry update |
| upd_ptr | output | 5 | Upper-level entry to update |
| upd_line | output | 6 | Line to update |
| upd_ind | output | 6 | New indicator for that line |

## Verification
The assertions check the following on every cycle:
- every eviction command names a local level;
- `ready` is low whenever a command is issued;
- an upper-level update only ever travels with a command or a response;
- the return of `ready` always comes with a response.

Only the bench scenarios can show the rest:
- where an allocate lands, including the invalid-first choice and the rotating choice;
- the ascending order and exact contents of a walk;
- that a missed update leaves the stored indicators untouched.

The bench fills all 64 entries and sweeps every line of a whole set. Its expected values come from a model built from the requirements.

// File: rtl/region_loc_store.sv
module region_loc_store #(
  parameter int PPN_W  = 20,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int LINES  = 64,
  parameter int LWAY_W = 3,
  parameter int UP_W   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [1:0]                req_op,
  input  logic [PPN_W-1:0]          req_ppn,
  input  logic [$clog2(LINES)-1:0]  req_line,
  input  logic [LWAY_W+2:0]         req_ind,
  input  logic [UP_W-1:0]           req_uptr,
  input  logic                      req_uptr_vld,
  output logic                      ready,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [$clog2(SETS*WAYS)-1:0] rsp_idx,
  output logic [LWAY_W+2:0]         rsp_ind,
  output logic                      evc_valid,
  output logic [PPN_W-1:0]          evc_ppn,
  output logic [$clog2(LINES)-1:0]  evc_line,
  output logic [LWAY_W+2:0]         evc_ind,
  output logic                      upd_valid,
  output logic [UP_W-1:0]           upd_ptr,
  output logic [$clog2(LINES)-1:0]  upd_line,
  output logic [LWAY_W+2:0]         upd_ind
);
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LINE_W  = $clog2(LINES);
  localparam int ENTRIES = SETS * WAYS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int IND_W   = LWAY_W + 3;
  localparam int FLD_W   = LWAY_W + 2;
  localparam logic [1:0] OP_LOOK = 2'd0, OP_ALLOC = 2'd1, OP_UPD = 2'd2, OP_EVICT = 2'd3;
  localparam logic [2:0] PFX_L1 = 3'b001, PFX_L2 = 3'b010;

  function automatic logic [IND_W-1:0] fld2ind(input logic [FLD_W-1:0] f);
    if (!f[FLD_W-1]) return '0;
    return {(f[FLD_W-2] ? PFX_L2 : PFX_L1), f[LWAY_W-1:0]};
  endfunction

  function automatic logic [FLD_W-1:0] ind2fld(input logic [IND_W-1:0] i);
    if (i[IND_W-1 -: 3] == PFX_L1) return {2'b10, i[LWAY_W-1:0]};
    if (i[IND_W-1 -: 3] == PFX_L2) return {2'b11, i[LWAY_W-1:0]};
    return '0;
  endfunction

  logic [PPN_W-1:0]       tag_q   [ENTRIES];
  logic [UP_W-1:0]        up_q    [ENTRIES];
  logic [LINES*FLD_W-1:0] lines_q [ENTRIES];
  logic [ENTRIES-1:0]     vld_q, uv_q;
  logic [WAY_W-1:0]       rr_q    [SETS];

  logic                   busy_q, wk_inst, wk_uv;
  logic [IDX_W-1:0]       wk_e;
  logic [PPN_W-1:0]       wk_ppn;
  logic [UP_W-1:0]        wk_up;

  logic [SET_W-1:0] set_i;
  logic             hit, ffound, wk_fnd;
  logic [WAY_W-1:0] hway, fway, vway;
  logic [IDX_W-1:0] hit_e, vic_e;
  logic [LINE_W-1:0] wk_ln;
  logic [FLD_W-1:0] cur_fld, new_fld;

  assign set_i   = req_ppn[SET_W-1:0];
  assign ready   = !busy_q;
  assign vway    = ffound ? fway : rr_q[set_i];
  assign hit_e   = {set_i, hway};
  assign vic_e   = {set_i, vway};
  assign cur_fld = lines_q[hit_e][req_line*FLD_W +: FLD_W];
  assign new_fld = ind2fld(req_ind);

  always_comb begin
    logic [IDX_W-1:0] e;
    hit = 1'b0; hway = '0; ffound = 1'b0; fway = '0;
    for (int w = 0; w < WAYS; w++) begin
      e = {set_i, WAY_W'(w)};
      if (vld_q[e] && tag_q[e] == req_ppn && !hit) begin
        hit = 1'b1; hway = WAY_W'(w);
      end
      if (!vld_q[e] && !ffound) begin
        ffound = 1'b1; fway = WAY_W'(w);
      end
    end
  end

  always_comb begin
    wk_fnd = 1'b0; wk_ln = '0;
    for (int l = LINES - 1; l >= 0; l--) begin
      if (lines_q[wk_e][l*FLD_W + FLD_W - 1]) begin
        wk_fnd = 1'b1; wk_ln = LINE_W'(l);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0; up_q[i] <= '0; lines_q[i] <= '0;
      end
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      vld_q <= '0; uv_q <= '0;
      busy_q <= 1'b0; wk_inst <= 1'b0; wk_uv <= 1'b0;
      wk_e <= '0; wk_ppn <= '0; wk_up <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_idx <= '0; rsp_ind <= '0;
      evc_valid <= 1'b0; evc_ppn <= '0; evc_line <= '0; evc_ind <= '0;
      upd_valid <= 1'b0; upd_ptr <= '0; upd_line <= '0; upd_ind <= '0;
    end else begin
      rsp_valid <= 1'b0;
      evc_valid <= 1'b0;
      upd_valid <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          rsp_hit <= 1'b0; rsp_idx <= '0; rsp_ind <= '0;
          case (req_op)
            OP_LOOK: begin
              rsp_valid <= 1'b1;
              rsp_hit   <= hit;
              if (hit) begin
                rsp_idx <= hit_e;
                rsp_ind <= fld2ind(cur_fld);
              end
            end
            OP_UPD: begin
              rsp_valid <= 1'b1;
              rsp_hit   <= hit;
              if (hit) begin
                lines_q[hit_e][req_line*FLD_W +: FLD_W] <= new_fld;
                rsp_idx <= hit_e;
                rsp_ind <= fld2ind(new_fld);
                if (uv_q[hit_e]) begin
                  upd_valid <= 1'b1;
                  upd_ptr   <= up_q[hit_e];
                  upd_line  <= req_line;
                  upd_ind   <= fld2ind(new_fld);
                end
              end
            end
            OP_ALLOC: begin
              if (hit) begin
                rsp_valid <= 1'b1; rsp_hit <= 1'b1; rsp_idx <= hit_e;
              end else if (!vld_q[vic_e]) begin
                tag_q[vic_e]   <= req_ppn;
                vld_q[vic_e]   <= 1'b1;
                lines_q[vic_e] <= '0;
                up_q[vic_e]    <= req_uptr;
                uv_q[vic_e]    <= req_uptr_vld;
                rr_q[set_i]    <= rr_q[set_i] + 1'b1;
                rsp_valid <= 1'b1; rsp_idx <= vic_e;
              end else begin
                busy_q <= 1'b1; wk_e <= vic_e; wk_inst <= 1'b1;
                wk_ppn <= req_ppn; wk_up <= req_uptr; wk_uv <= req_uptr_vld;
              end
            end
            default: begin
              if (hit) begin
                busy_q <= 1'b1; wk_e <= hit_e; wk_inst <= 1'b0;
              end else begin
                rsp_valid <= 1'b1;
              end
            end
          endcase
        end
      end else if (wk_fnd) begin
        evc_valid <= 1'b1;
        evc_ppn   <= tag_q[wk_e];
        evc_line  <= wk_ln;
        evc_ind   <= fld2ind(lines_q[wk_e][wk_ln*FLD_W +: FLD_W]);
        lines_q[wk_e][wk_ln*FLD_W +: FLD_W] <= '0;
        if (uv_q[wk_e]) begin
          upd_valid <= 1'b1;
          upd_ptr   <= up_q[wk_e];
          upd_line  <= wk_ln;
          upd_ind   <= '0;
        end
      end else begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_idx   <= wk_e;
        rsp_ind   <= '0;
        if (wk_inst) begin
          tag_q[wk_e] <= wk_ppn;
          up_q[wk_e]  <= wk_up;
          uv_q[wk_e]  <= wk_uv;
          rr_q[wk_e[IDX_W-1:WAY_W]] <= rr_q[wk_e[IDX_W-1:WAY_W]] + 1'b1;
          rsp_hit <= 1'b0;
        end else begin
          vld_q[wk_e] <= 1'b0;
          uv_q[wk_e]  <= 1'b0;
          rsp_hit <= 1'b1;
        end
      end
    end
  end

  a_r7_evc_names_level: assert property (@(posedge clk) disable iff (!rst_n)
    evc_valid |-> (evc_ind[IND_W-1 -: 3] == PFX_L1 || evc_ind[IND_W-1 -: 3] == PFX_L2));
  a_r7_walk_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    evc_valid |-> !ready);
  a_r5_upd_paired: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (evc_valid || rsp_valid));
  a_r7_ready_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> rsp_valid);
  a_r2_hit_has_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit && rsp_valid |-> !evc_valid);
endmodule

// File: tb/region_loc_store_test.sv
`timescale 1ns/1ps
module region_loc_store_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_uptr_vld = 1'b0;
  logic [1:0] req_op = '0;
  logic [19:0] req_ppn = '0;
  logic [5:0] req_line = '0, req_ind = '0;
  logic [4:0] req_uptr = '0;
  logic ready, rsp_valid, rsp_hit, evc_valid, upd_valid;
  logic [5:0] rsp_idx, rsp_ind, evc_line, evc_ind, upd_line, upd_ind;
  logic [19:0] evc_ppn;
  logic [4:0] upd_ptr;

  region_loc_store uut (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL all watchdog: actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  logic [19:0] m_tag [64];
  bit          m_vld [64];
  bit          m_uv  [64];
  int          m_up  [64];
  logic [5:0]  m_loc [64][64];
  int          m_rr  [16];

  int ev_cnt;
  logic [5:0] ev_line [64];
  logic [5:0] ev_ind [64];
  logic [19:0] ev_ppn [64];
  bit ev_upd [64];
  logic [4:0] ev_uptr [64];
  logic [5:0] ev_uind [64];
  bit r_hit, r_upd;
  logic [5:0] r_idx, r_ind, r_uline, r_uind;
  logic [4:0] r_uptr;

  function automatic int mfind(input logic [19:0] ppn);
    for (int w = 0; w < 4; w++)
      if (m_vld[ppn[3:0]*4+w] && m_tag[ppn[3:0]*4+w] == ppn) return ppn[3:0]*4+w;
    return -1;
  endfunction

  function automatic int mvic(input int s);
    for (int w = 0; w < 4; w++) if (!m_vld[s*4+w]) return s*4+w;
    return s*4 + m_rr[s];
  endfunction

  function automatic logic [5:0] mnorm(input logic [5:0] i);
    return (i[5:3] == 3'b001 || i[5:3] == 3'b010) ? i : 6'd0;
  endfunction

  task automatic send(input logic [1:0] op, input logic [19:0] ppn, input int line,
                      input logic [5:0] ind, input int up, input bit uv);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_ppn = ppn; req_line = 6'(line);
    req_ind = ind; req_uptr = 5'(up); req_uptr_vld = uv;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ev_cnt = 0; guard = 0;
    while (!rsp_valid && guard < 200) begin
      chk("R7", "ready low during walk", ready, 0);
      if (evc_valid && ev_cnt < 64) begin
        ev_line[ev_cnt] = evc_line; ev_ind[ev_cnt] = evc_ind; ev_ppn[ev_cnt] = evc_ppn;
        ev_upd[ev_cnt] = upd_valid; ev_uptr[ev_cnt] = upd_ptr; ev_uind[ev_cnt] = upd_ind;
        ev_cnt++;
      end
      guard++;
      @(negedge clk);
    end
    chk("R2", "response arrives", guard < 200, 1);
    chk("R7", "no command with response", evc_valid, 0);
    r_hit = rsp_hit; r_idx = rsp_idx; r_ind = rsp_ind;
    r_upd = upd_valid; r_uptr = upd_ptr; r_uline = upd_line; r_uind = upd_ind;
  endtask

  task automatic chk_walk(input int v, input string rq);
    int n = 0;
    if (m_vld[v]) begin
      for (int l = 0; l < 64; l++) begin
        if (m_loc[v][l] != 0) begin
          if (n < ev_cnt) begin
            chk(rq, "walk line order", ev_line[n], l);
            chk(rq, "walk indicator", ev_ind[n], m_loc[v][l]);
            chk(rq, "walk page", ev_ppn[n], m_tag[v]);
            chk(rq, "walk upper pulse", ev_upd[n], m_uv[v]);
            if (m_uv[v]) begin
              chk(rq, "walk upper ptr", ev_uptr[n], m_up[v]);
              chk(rq, "walk upper ind", ev_uind[n], 0);
            end
          end
          n++;
        end
      end
    end
    chk(rq, "walk command count", ev_cnt, n);
  endtask

  task automatic op_lookup(input logic [19:0] ppn, input int line);
    int e = mfind(ppn);
    send(2'd0, ppn, line, 6'd0, 0, 1'b0);
    chk("R2", "lookup hit", r_hit, e >= 0);
    if (e >= 0) begin
      chk("R2", "lookup idx", r_idx, e);
      chk("R3", "lookup indicator", r_ind, m_loc[e][line]);
    end
    chk("R2", "no upper pulse on lookup", r_upd, 0);
  endtask

  task automatic op_update(input logic [19:0] ppn, input int line, input logic [5:0] ind);
    int e = mfind(ppn);
    send(2'd2, ppn, line, ind, 0, 1'b0);
    chk("R4", "update hit", r_hit, e >= 0);
    if (e >= 0) begin
      chk("R5", "upper pulse presence", r_upd, m_uv[e]);
      if (m_uv[e]) begin
        chk("R5", "upper ptr", r_uptr, m_up[e]);
        chk("R5", "upper line", r_uline, line);
        chk("R5", "upper ind", r_uind, mnorm(ind));
      end
      m_loc[e][line] = mnorm(ind);
    end else begin
      chk("R4", "miss gives no upper pulse", r_upd, 0);
    end
  endtask

  task automatic op_alloc(input logic [19:0] ppn, input int up, input bit uv);
    int e = mfind(ppn);
    int v;
    if (e >= 0) begin
      send(2'd1, ppn, 0, 6'd0, up, uv);
      chk("R6", "alloc existing hit", r_hit, 1);
      chk("R6", "alloc existing idx", r_idx, e);
      chk("R6", "alloc existing no walk", ev_cnt, 0);
      return;
    end
    v = mvic(ppn[3:0]);
    send(2'd1, ppn, 0, 6'd0, up, uv);
    chk("R6", "alloc fresh hit", r_hit, 0);
    chk("R6", "alloc victim idx", r_idx, v);
    chk_walk(v, "R7");
    m_vld[v] = 1; m_tag[v] = ppn; m_uv[v] = uv; m_up[v] = up;
    for (int l = 0; l < 64; l++) m_loc[v][l] = 6'd0;
    m_rr[ppn[3:0]] = (m_rr[ppn[3:0]] + 1) % 4;
  endtask

  task automatic op_evict(input logic [19:0] ppn);
    int e = mfind(ppn);
    send(2'd3, ppn, 0, 6'd0, 0, 1'b0);
    chk("R8", "evict hit", r_hit, e >= 0);
    if (e >= 0) begin
      chk("R8", "evict idx", r_idx, e);
      chk_walk(e, "R8");
      m_vld[e] = 0;
    end else begin
      chk("R8", "evict miss no commands", ev_cnt, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_vld[i] = 0; m_uv[i] = 0; m_up[i] = 0; m_tag[i] = '0;
      for (int l = 0; l < 64; l++) m_loc[i][l] = 6'd0;
    end
    for (int s = 0; s < 16; s++) m_rr[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", ready, 1);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk("R1", "evc_valid after reset", evc_valid, 0);
    chk("R1", "upd_valid after reset", upd_valid, 0);
    for (int s = 0; s < 16; s++) op_lookup(20'(s * 37), s);

    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 16; s++)
        op_alloc(20'(s + 16 * k + 256), (s * 4 + k) % 32, k != 3);

    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++)
        for (int j = 0; j < 4; j++)
          op_update(20'(s + 16 * k + 256), (s * 7 + k * 13 + j * 5) % 64,
                    {(j % 2) ? 3'b010 : 3'b001, 3'((s + j) % 8)});
    for (int l = 0; l < 20; l++)
      op_update(20'(256), l * 3, {(l % 2) ? 3'b001 : 3'b010, 3'(l % 8)});
    op_update(20'(256), 3, 6'b100101);
    op_update(20'(256), 6, 6'b000111);
    op_lookup(20'(256), 3);
    op_lookup(20'(256), 6);

    op_update(20'h99999, 5, 6'b001011);
    op_update(20'h00009, 5, 6'b010011);

    for (int k = 0; k < 4; k++)
      for (int l = 0; l < 64; l++) op_lookup(20'(2 + 16 * k + 256), l);

    op_alloc(20'(7 + 16 * 2 + 256), 3, 1'b1);

    for (int s = 0; s < 4; s++) op_alloc(20'(s + 16 * 8 + 256), 20 + s, 1'b1);
    op_lookup(20'(256), 0);
    op_lookup(20'(16 * 8 + 256), 9);
    op_update(20'(16 * 8 + 256), 9, 6'b010111);
    op_alloc(20'(16 * 9 + 256), 30, 1'b0);
    op_alloc(20'(16 * 10 + 256), 31, 1'b1);

    op_evict(20'(5 + 48 + 256));
    op_evict(20'(6 + 16 + 256));
    op_evict(20'(6 + 16 + 256));
    op_lookup(20'(6 + 16 + 256), 0);
    op_alloc(20'(6 + 16 * 12 + 256), 2, 1'b1);
    op_evict(20'h7777F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule